// File: doc/BRIEF.md
# Dual-Mode Serial Audio Output Formatter

This block turns four parallel 24-bit PCM samples, organised as two stereo pairs (A and B), into serial audio data. It is a clock slave: the bit clock and the word clock both arrive from outside, so the output frame rate follows whatever word clock is supplied. Both clocks are oversampled in the system clock domain through synchronizers. Every output change follows a detected falling edge of the bit clock, so a receiver can sample on the rising edge.

A static select picks one of two formats. In left-justified mode (`tdm_en` = 0), pair A goes out on `sd_a` and pair B on `sd_b`. The bit clock runs at 64 times the word clock, which gives 32 bit periods per channel. In TDM mode (`tdm_en` = 1), the bit clock runs at 128 times the word clock. All four channels share `sd_b` in four 32-period slots, and `sd_a` is parked low. All four parallel inputs are captured together when a frame starts, so the source may update them at any time during the frame.

A frame starts at the first bit-clock falling edge at which the synchronized word clock reads high, after it read low at the previous falling edge. Every slot is MSB-first with no one-bit delay. The MSB goes out in the first bit period of the slot. The 8 positions after the LSB are zero.

Top module: `audio_dual_fmt_tx`

## Requirements
- R1: While `rst` is high, and after reset until the first bit-clock falling edge, `sd_a` and `sd_b` are 0.
- R2: With `tdm_en` = 0, `sd_a` carries `pa_left` in the 32 bit periods that begin at the frame start and `pa_right` in the next 32. Each word is sent MSB (bit 23) first, in the first period of its slot.
- R3: With `tdm_en` = 0, `sd_b` carries `pb_left` and then `pb_right` with the same timing and bit order as R2.
- R4: Bit positions 24 to 31 of every 32-period slot are 0 on both lines, in both modes.
- R5: With `tdm_en` = 1, `sd_b` carries four 32-period slots starting at the frame start. The slots are, in order, `pb_left`, `pb_right`, `pa_left`, `pa_right`, each MSB first.
- R6: With `tdm_en` = 1, `sd_a` is 0.
- R7: All four sample inputs are captured at the falling edge that starts a frame. A later change has no effect on the frame in progress and appears in the next frame.
- R8: The data lines change only in response to a detected bit-clock falling edge, no later than SYNC_STAGES+2 system clocks after it. They then hold steady for the rest of that bit period.
- R9: A frame start seen at any bit position restarts transmission at slot 0, MSB. Without one, the bit position keeps counting and wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | External serial bit clock |
| word_clk | input | 1 | External word clock; high for the left half in left-justified mode, rising edge marks the frame |
| tdm_en | input | 1 | Static format select: 0 left-justified, 1 four-slot TDM |
| pa_left | input | SAMPLE_W | Pair A left sample |
| pa_right | input | SAMPLE_W | Pair A right sample |
| pb_left | input | SAMPLE_W | Pair B left sample |
| pb_right | input | SAMPLE_W | Pair B right sample |
| sd_a | output | 1 | Pair A serial data (left-justified mode only) |
| sd_b | output | 1 | Pair B serial data, or the TDM stream |

## Verification
A wrong bit-position count or a missed frame start shows up at once as wrong bits on the data lines. It appears in the first bit period after the fault: either a misplaced MSB or nonzero padding where positions 24 to 31 should be. A capture register that loads outside the frame start shows up as a mid-frame change in the word being sent. A wrong slot selection in TDM mode shows up as the wrong channel in a whole 32-period slot. The bench checks every bit period of every frame twice, once just after the rising edge and once just before the next falling edge. Any of these faults is therefore reported within one bit period.

// File: rtl/sao_pkg.sv
package sao_pkg;
  // Index of each channel inside the captured sample vector; the value is
  // also the TDM slot number, so the order here is the on-wire order.
  typedef enum logic [1:0] {
    SLOT_BL = 2'd0,
    SLOT_BR = 2'd1,
    SLOT_AL = 2'd2,
    SLOT_AR = 2'd3
  } tdm_slot_e;

  localparam int unsigned NUM_CH = 4;
endpackage

// File: rtl/sao_edge_sync.sv
module sao_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic fell
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign level = pipe[STAGES-1];
  assign fell  = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/sao_frame_pos.sv
module sao_frame_pos #(
  parameter int unsigned POS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_fall,
  input  logic             word_lvl,
  output logic             frame_hit,
  output logic [POS_W-1:0] pos,
  output logic             step
);
  logic word_seen;  // word clock level at the previous bit-clock fall

  assign frame_hit = bit_fall & word_lvl & ~word_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_seen <= 1'b0;
      pos       <= '0;
      step      <= 1'b0;
    end else begin
      step <= bit_fall;
      if (bit_fall) begin
        word_seen <= word_lvl;
        pos       <= frame_hit ? '0 : pos + 1'b1;
      end
    end
  end

  // R9: a frame start always brings the position back to slot 0, MSB
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    frame_hit |=> (pos == '0));

  // R9: without a frame start the position advances by one per bit
  p_advance_r9: assert property (@(posedge clk) disable iff (rst)
    (bit_fall && !frame_hit) |=> (pos == $past(pos) + 1'b1));

  // R8: position only moves on a detected falling edge
  p_pos_still_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_fall |=> $stable(pos));
endmodule

// File: rtl/sao_capture.sv
module sao_capture #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned NCH      = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         take,
  input  logic [NCH-1:0][SAMPLE_W-1:0] din,
  output logic [NCH-1:0][SAMPLE_W-1:0] held
);
  logic [SAMPLE_W-1:0] regs [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)       regs[c] <= '0;
      else if (take) regs[c] <= din[c];
    end
    assign held[c] = regs[c];
  end

  // R7: captured words are frozen between frame starts
  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(held));
endmodule

// File: rtl/sao_shifter.sv
module sao_shifter
  import sao_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SLOT_W   = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            step,
  input  logic                            tdm_en,
  input  logic [$clog2(SLOT_W)+1:0]       pos,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] words,
  output logic                            sd_a,
  output logic                            sd_b
);
  localparam int unsigned BIT_W = $clog2(SLOT_W);
  localparam int unsigned IDX_W = $clog2(SAMPLE_W);

  logic [BIT_W-1:0]    bit_idx;
  logic [BIT_W-1:0]    rev;
  logic [IDX_W-1:0]    pick;
  logic                in_word;
  logic                half;
  logic [1:0]          slot;
  logic [SAMPLE_W-1:0] a_word, b_word, t_word;
  logic                nxt_a, nxt_b;

  always_comb begin
    bit_idx = pos[BIT_W-1:0];
    in_word = (32'(bit_idx) < SAMPLE_W);
    rev     = BIT_W'(SAMPLE_W - 1) - bit_idx;
    pick    = rev[IDX_W-1:0];
    half    = pos[BIT_W];
    slot    = pos[BIT_W+1:BIT_W];
    a_word  = half ? words[SLOT_AR] : words[SLOT_AL];
    b_word  = half ? words[SLOT_BR] : words[SLOT_BL];
    t_word  = words[slot];
    nxt_a   = ~tdm_en & in_word & a_word[pick];
    nxt_b   = in_word & (tdm_en ? t_word[pick] : b_word[pick]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_a <= 1'b0;
      sd_b <= 1'b0;
    end else if (step) begin
      sd_a <= nxt_a;
      sd_b <= nxt_b;
    end
  end

  // R6: pair A line parked low in TDM mode
  p_tdm_a_low_r6: assert property (@(posedge clk) disable iff (rst)
    (step && tdm_en) |=> !sd_a);

  // R4: padding positions after the LSB are zero
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (step && (32'(pos[BIT_W-1:0]) >= SAMPLE_W)) |=> (!sd_a && !sd_b));

  // R8: lines move only on a bit-clock fall update
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(sd_a) && $stable(sd_b)));
endmodule

// File: rtl/audio_dual_fmt_tx.sv
module audio_dual_fmt_tx
  import sao_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned SLOT_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_clk,
  input  logic                word_clk,
  input  logic                tdm_en,
  input  logic [SAMPLE_W-1:0] pa_left,
  input  logic [SAMPLE_W-1:0] pa_right,
  input  logic [SAMPLE_W-1:0] pb_left,
  input  logic [SAMPLE_W-1:0] pb_right,
  output logic                sd_a,
  output logic                sd_b
);
  localparam int unsigned BIT_W = $clog2(SLOT_W);
  localparam int unsigned POS_W = BIT_W + 2;

  logic                            bclk_lvl, bclk_fall;
  logic                            wclk_lvl, wclk_fall_unused;
  logic                            frame_hit, step;
  logic [POS_W-1:0]                pos;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] raw, held;

  assign raw[SLOT_BL] = pb_left;
  assign raw[SLOT_BR] = pb_right;
  assign raw[SLOT_AL] = pa_left;
  assign raw[SLOT_AR] = pa_right;

  sao_edge_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
    .clk(clk), .rst(rst), .async_in(bit_clk),
    .level(bclk_lvl), .fell(bclk_fall)
  );

  sao_edge_sync #(.STAGES(SYNC_STAGES)) u_wclk_sync (
    .clk(clk), .rst(rst), .async_in(word_clk),
    .level(wclk_lvl), .fell(wclk_fall_unused)
  );

  sao_frame_pos #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .bit_fall(bclk_fall), .word_lvl(wclk_lvl),
    .frame_hit(frame_hit), .pos(pos), .step(step)
  );

  sao_capture #(.SAMPLE_W(SAMPLE_W), .NCH(NUM_CH)) u_cap (
    .clk(clk), .rst(rst), .take(frame_hit), .din(raw), .held(held)
  );

  sao_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst(rst), .step(step), .tdm_en(tdm_en),
    .pos(pos), .words(held), .sd_a(sd_a), .sd_b(sd_b)
  );

  // R1: both lines low during reset recovery until a bit is shifted
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!sd_a && !sd_b));

  // R7: capture happens only on a frame start, which needs a bit-clock fall
  p_take_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    frame_hit |-> (bclk_fall && wclk_lvl));

  // bclk_lvl and wclk_fall_unused are left to the synchronizer outputs
  logic unused_ok;
  assign unused_ok = bclk_lvl ^ wclk_fall_unused;
endmodule

// File: tb/audio_dual_fmt_tx_tb.sv
module audio_dual_fmt_tx_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic bit_clk = 1'b1, word_clk = 1'b0, tdm_en = 1'b0;
  logic [23:0] pa_left = '0, pa_right = '0, pb_left = '0, pb_right = '0;
  logic sd_a, sd_b;

  int vectors = 0;
  int miscompares = 0;

  // index 0 = B left, 1 = B right, 2 = A left, 3 = A right
  logic [3:0][23:0] frame_w;

  audio_dual_fmt_tx u_dut (
    .clk(clk), .rst(rst), .bit_clk(bit_clk), .word_clk(word_clk),
    .tdm_en(tdm_en), .pa_left(pa_left), .pa_right(pa_right),
    .pb_left(pb_left), .pb_right(pb_right), .sd_a(sd_a), .sd_b(sd_b)
  );

  task automatic check_bit(string tag, string line, int pos, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s line %s pos %0d: actual %b expected %b", tag, line, pos, act, exp);
    end
  endtask

  function automatic logic exp_bit(bit tdm, bit line_b, int pos, logic [3:0][23:0] w);
    int b = pos % 32;
    if (b >= 24) return 1'b0;
    if (tdm) begin
      if (!line_b) return 1'b0;
      return w[(pos / 32) % 4][23 - b];
    end
    if (line_b) return ((pos / 32) % 2) ? w[1][23 - b] : w[0][23 - b];
    return ((pos / 32) % 2) ? w[3][23 - b] : w[2][23 - b];
  endfunction

  function automatic string tag_for(bit tdm, bit line_b, int pos, string ovr);
    if (ovr != "") return ovr;
    if (pos % 32 >= 24) return "R4";
    if (tdm) return line_b ? "R5" : "R6";
    return line_b ? "R3" : "R2";
  endfunction

  function automatic logic [23:0] pat(int f, int c);
    logic [31:0] x;
    if (f == 0) return 24'hFFFFFF;
    if (f == 1) return (c % 2) ? 24'h000001 : 24'h800000;
    x = f * 32'h9E3779B1 + c * 32'h7F4A7C15;
    return x[23:0] ^ (24'h1 << ((f * 4 + c) % 24));
  endfunction

  task automatic drive_inputs(logic [3:0][23:0] v);
    pb_left = v[0]; pb_right = v[1]; pa_left = v[2]; pa_right = v[3];
  endtask

  // One frame: nbits bit periods, word clock high for the first high_bits.
  task automatic run_frame(bit tdm, int nbits, int high_bits, int change_at,
                           logic [3:0][23:0] vals, logic [3:0][23:0] late,
                           string ovr);
    tdm_en = tdm;
    drive_inputs(vals);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bit_clk  = 1'b0;
      word_clk = (i < high_bits);
      if (i == 0) frame_w = vals;
      if (i == change_at) drive_inputs(late);
      repeat (8) @(negedge clk);
      bit_clk = 1'b1;
      check_bit(tag_for(tdm, 1'b0, i, ovr), "a", i, sd_a, exp_bit(tdm, 1'b0, i, frame_w));
      check_bit(tag_for(tdm, 1'b1, i, ovr), "b", i, sd_b, exp_bit(tdm, 1'b1, i, frame_w));
      repeat (7) @(negedge clk);
      check_bit("R8", "a", i, sd_a, exp_bit(tdm, 1'b0, i, frame_w));
      check_bit("R8", "b", i, sd_b, exp_bit(tdm, 1'b1, i, frame_w));
    end
  endtask

  function automatic logic [3:0][23:0] frame_pat(int f);
    logic [3:0][23:0] v;
    for (int c = 0; c < 4; c++) v[c] = pat(f, c);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [3:0][23:0] v0, v1;
    repeat (6) @(negedge clk);
    check_bit("R1", "a", -1, sd_a, 1'b0);
    check_bit("R1", "b", -1, sd_b, 1'b0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check_bit("R1", "a", -1, sd_a, 1'b0);
    check_bit("R1", "b", -1, sd_b, 1'b0);

    // left-justified sweep
    for (int f = 0; f < 4; f++) run_frame(1'b0, 64, 32, -1, frame_pat(f), frame_pat(f), "");
    // R7: inputs change mid-frame, take effect next frame
    v0 = frame_pat(10); v1 = frame_pat(11);
    run_frame(1'b0, 64, 32, 5, v0, v1, "R7");
    run_frame(1'b0, 64, 32, -1, v1, v1, "R7");
    // R9: truncated frame then a full one starting at MSB
    run_frame(1'b0, 40, 20, -1, frame_pat(12), frame_pat(12), "R9");
    run_frame(1'b0, 64, 32, -1, frame_pat(13), frame_pat(13), "R9");

    // TDM sweep
    for (int f = 0; f < 4; f++) run_frame(1'b1, 128, 64, -1, frame_pat(f), frame_pat(f), "");
    v0 = frame_pat(20); v1 = frame_pat(21);
    run_frame(1'b1, 128, 64, 70, v0, v1, "R7");
    run_frame(1'b1, 128, 1, -1, v1, v1, "R7");
    run_frame(1'b1, 70, 10, -1, frame_pat(22), frame_pat(22), "R9");
    run_frame(1'b1, 128, 64, -1, frame_pat(23), frame_pat(23), "R9");

    // back to left-justified after TDM
    run_frame(1'b0, 64, 32, -1, frame_pat(5), frame_pat(5), "");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule